// File: doc/BRIEF.md
# Byte-Addressable Little-Endian Data Memory

This block is a data memory built from 16-bit words that software addresses in bytes. Each request names a byte address, chooses a byte-sized or a word-sized transfer, and says whether it reads or writes. Internally the store is split into a low byte lane and a high byte lane. Bit 0 of the address picks the lane, and the remaining address bits pick the word.

Byte reads come back zero-extended in the low half of the read data. Byte writes touch only the addressed lane. A word request at an odd address is flagged as misaligned and is then carried out at the even address just below it.

A request is sampled on one clock edge. It executes on the following edge, and its response appears at that same edge. A write therefore becomes visible to any request sampled on the edge at which the write executes, or on any later edge. No stall or forwarding logic is needed.

Top module: `bytemem_port`

## Requirements
- R1: Lane mapping is little-endian. Byte address 2k holds bits 7:0 of word k, and byte address 2k+1 holds bits 15:8 of word k.
- R2: A word is addressed by its even byte address, so words k and k+1 sit at byte addresses 2k and 2k+2. A write to one word leaves its neighbour unchanged.
- R3: A word read (`req_byte`=0, `req_we`=0) returns all 16 bits of the word. A word write replaces all 16 bits.
- R4: A byte read (`req_byte`=1) returns the addressed byte in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]` equal to zero.
- R5: A byte write stores `req_wdata[7:0]` into the addressed lane only. The other lane of that word keeps its value, and `req_wdata[15:8]` is ignored.
- R6: A word request with `req_addr[0]`=1 raises `rsp_misalign` together with its response and is performed at the address with bit 0 cleared. Byte requests and even-address word requests never raise `rsp_misalign`.
- R7: A request sampled with `req_valid`=1 at clock edge k produces `rsp_valid`=1 for exactly one cycle after edge k+1, with read data in `rsp_rdata`. A write executes at edge k+1, so a read sampled at edge k+1 returns the new data.
- R8: A write request also produces a `rsp_valid` pulse, and `rsp_rdata` keeps the value it had before the write.
- R9: While `rst_n` is low, `rsp_valid` and `rsp_misalign` are 0 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data; only bits 7:0 are used for byte writes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_misalign | output | 1 | Word request had an odd address |
| rsp_rdata | output | 16 | Read data, zero-extended for byte reads |

## Verification
The case of interest is a write to a word executing on the same edge at which a read of that same word is sampled. Both pass through the single request stage, so the question is whether the read returns the old contents or the new ones. The bench issues a word write and, in the very next cycle, a read of the same address, with no idle cycle between them. It then checks that the write's response pulse and the read's response pulse arrive on consecutive cycles and that the read returns the freshly written value. A second case puts a misaligned word write next to byte reads of the same word. This confirms that the error flag follows only the request that earned it and that the data landed at the even address.

// File: rtl/bytemem_port.sv
module bytemem_port #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_misalign,
  output logic [15:0]       rsp_rdata
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int WORDS = 1 << IDX_W;

  logic             s_vld, s_we, s_byte, s_lane;
  logic [IDX_W-1:0] s_idx;
  logic [15:0]      s_wdata;

  logic [7:0] lo_mem [WORDS];
  logic [7:0] hi_mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld   <= 1'b0;
      s_we    <= 1'b0;
      s_byte  <= 1'b0;
      s_lane  <= 1'b0;
      s_idx   <= '0;
      s_wdata <= '0;
    end else begin
      s_vld <= req_valid;
      if (req_valid) begin
        s_we    <= req_we;
        s_byte  <= req_byte;
        s_lane  <= req_addr[0];
        s_idx   <= req_addr[ADDR_W-1:1];
        s_wdata <= req_wdata;
      end
    end
  end

  wire wr_lo = s_vld & s_we & ~(s_byte & s_lane);
  wire wr_hi = s_vld & s_we & ~(s_byte & ~s_lane);
  wire [7:0] hi_in = s_byte ? s_wdata[7:0] : s_wdata[15:8];

  always_ff @(posedge clk) begin
    if (wr_lo) lo_mem[s_idx] <= s_wdata[7:0];
    if (wr_hi) hi_mem[s_idx] <= hi_in;
  end

  wire [15:0] word_rd = {hi_mem[s_idx], lo_mem[s_idx]};
  wire [15:0] byte_rd = {8'h00, s_lane ? hi_mem[s_idx] : lo_mem[s_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid    <= s_vld;
      rsp_misalign <= s_vld & ~s_byte & s_lane;
      if (s_vld && !s_we) rsp_rdata <= s_byte ? byte_rd : word_rd;
    end
  end
endmodule

// File: rtl/bytemem_port_chk.sv
module bytemem_port_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic              req_byte,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_misalign,
  input logic [15:0]       rsp_rdata
);
  a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid, 2));

  a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && !req_we && req_byte, 2)) |-> (rsp_rdata[15:8] == 8'h00));

  a_r6_misalign_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_misalign |-> rsp_valid);

  a_r6_misalign_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_misalign == $past(!req_byte && req_addr[0], 2)));

  a_r8_write_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && req_we, 2)) |-> $stable(rsp_rdata));
endmodule

bind bytemem_port bytemem_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_byte(req_byte), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_misalign(rsp_misalign), .rsp_rdata(rsp_rdata)
);

// File: tb/test_bytemem_port.sv
module test_bytemem_port;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_we = 1'b0;
  logic              req_byte = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0]       req_wdata = '0;
  logic              rsp_valid, rsp_misalign;
  logic [15:0]       rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bytemem_port #(.ADDR_W(ADDR_W)) i_bytemem_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic bsel, input logic [ADDR_W-1:0] a,
                       input logic [15:0] wd);
    req_valid = 1'b1; req_we = we; req_byte = bsel; req_addr = a; req_wdata = wd;
  endtask

  task automatic single(input logic we, input logic bsel, input logic [ADDR_W-1:0] a,
                        input logic [15:0] wd);
    @(negedge clk); drive(we, bsel, a, wd);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R9 rsp_valid in reset", {15'd0, rsp_valid}, 16'd0);
    check("R9 rsp_misalign in reset", {15'd0, rsp_misalign}, 16'd0);
    check("R9 rsp_rdata in reset", rsp_rdata, 16'h0000);
  endtask

  task automatic t_word_and_lanes;
    single(1'b1, 1'b0, 10'd4, 16'h1234);
    check("R8 write rsp_valid", {15'd0, rsp_valid}, 16'd1);
    check("R8 write keeps rdata", rsp_rdata, 16'h0000);
    single(1'b0, 1'b0, 10'd4, 16'h0);
    check("R3 word read", rsp_rdata, 16'h1234);
    check("R6 aligned word no flag", {15'd0, rsp_misalign}, 16'd0);
    single(1'b0, 1'b1, 10'd4, 16'h0);
    check("R1 R4 even byte low lane", rsp_rdata, 16'h0034);
    single(1'b0, 1'b1, 10'd5, 16'h0);
    check("R1 R4 odd byte high lane", rsp_rdata, 16'h0012);
  endtask

  task automatic t_byte_write;
    single(1'b1, 1'b1, 10'd5, 16'hAB55);
    single(1'b0, 1'b0, 10'd4, 16'h0);
    check("R5 high byte write keeps low", rsp_rdata, 16'h5534);
    single(1'b1, 1'b1, 10'd4, 16'h77CC);
    single(1'b0, 1'b0, 10'd4, 16'h0);
    check("R5 low byte write keeps high", rsp_rdata, 16'h55CC);
  endtask

  task automatic t_neighbour;
    single(1'b1, 1'b0, 10'd6, 16'hBEEF);
    single(1'b0, 1'b0, 10'd4, 16'h0);
    check("R2 neighbour word untouched", rsp_rdata, 16'h55CC);
    single(1'b0, 1'b1, 10'd6, 16'h0);
    check("R2 R1 next word low byte", rsp_rdata, 16'h00EF);
    single(1'b0, 1'b1, 10'd7, 16'h0);
    check("R2 R1 next word high byte", rsp_rdata, 16'h00BE);
  endtask

  task automatic t_misalign;
    single(1'b1, 1'b0, 10'd9, 16'hCAFE);
    check("R6 misaligned write flag", {15'd0, rsp_misalign}, 16'd1);
    single(1'b0, 1'b0, 10'd8, 16'h0);
    check("R6 data at aligned address", rsp_rdata, 16'hCAFE);
    check("R6 flag clears", {15'd0, rsp_misalign}, 16'd0);
    single(1'b0, 1'b0, 10'd9, 16'h0);
    check("R6 misaligned read data", rsp_rdata, 16'hCAFE);
    check("R6 misaligned read flag", {15'd0, rsp_misalign}, 16'd1);
    single(1'b0, 1'b1, 10'd9, 16'h0);
    check("R6 odd byte read no flag", {15'd0, rsp_misalign}, 16'd0);
    check("R4 odd byte read", rsp_rdata, 16'h00CA);
    single(1'b1, 1'b1, 10'd8, 16'hFF11);
    check("R8 byte write keeps rdata", rsp_rdata, 16'h00CA);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); drive(1'b1, 1'b0, 10'd10, 16'h1111);
    @(negedge clk); drive(1'b0, 1'b0, 10'd10, 16'h0);
    @(negedge clk); req_valid = 1'b0;
    check("R7 first response", {15'd0, rsp_valid}, 16'd1);
    @(negedge clk);
    check("R7 second response", {15'd0, rsp_valid}, 16'd1);
    check("R7 read sees prior write", rsp_rdata, 16'h1111);
    @(negedge clk);
    check("R7 single-cycle pulse", {15'd0, rsp_valid}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_word_and_lanes();
    t_byte_write();
    t_neighbour();
    t_misalign();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule